// File: doc/BRIEF.md
# USB Device Interrupt Status Aggregator

This block gathers the device-level USB events and the per-endpoint interrupt requests into one read-only 32-bit status word, and reduces that word through an enable mask to a single registered interrupt line. Bus events arrive as one-cycle pulses: suspend, start of frame (carrying an 11-bit frame number), end of reset, wakeup, end of resume and upstream resume. Each pulse latches its own status bit. Firmware then acknowledges the bit by writing a one to the same position of a write-one-to-clear register.

Endpoint requests arrive as levels. They are mirrored straight into the status word and are never latched. Each one drops only when its endpoint logic services its source.

A clock-freeze input holds the latched bits still, with one exception: a wakeup indication from the line filter must still be captured. A rising suspend bit discards any pending wakeup. A simple register bus gives access to the status word, the clear register, the enable mask and the last captured frame number. The bus has a write strobe and a combinational read selected by address.

Top module: `usb_dev_irq_status`

## Requirements
- R1: After reset the status word (offset 0x04), the enable mask (offset 0x10), the frame number (offset 0x20) and `irq` are all zero.
- R2: A pulse on a device event sets its status bit at the next clock edge: suspend at bit 0, start of frame at bit 2, end of reset at bit 3, wakeup at bit 4, end of resume at bit 5, upstream resume at bit 6. Bits 1, 7 to 11 and 19 to 31 always read zero.
- R3: A write of ones to the clear register (offset 0x08) clears the matching latched bits at that edge. Zero bits in the write leave their status bits unchanged, and the clear register always reads zero.
- R4: Endpoint request `ep_req[i]` appears at status bit 12+i in the same cycle it is driven, and follows the level. Clear-register writes do not affect it.
- R5: When an event pulse and a clear write for the same bit fall on the same edge, the bit ends up set.
- R6: At the edge where the suspend bit goes from 0 to 1, the wakeup bit is cleared, even if a wakeup pulse arrives at that same edge. A suspend pulse while suspend is already set leaves wakeup unchanged.
- R7: While `freeze` is high, only a wakeup pulse changes the latched bits. All other event pulses and all clear writes are ignored, and the frame number holds.
- R8: An upstream-resume pulse sets bit 6 only and never sets the wakeup bit.
- R9: A start-of-frame pulse loads `sof_frame` into the 11-bit frame register, which reads at offset 0x20 with the upper bits zero. A change on `sof_frame` without a pulse has no effect.
- R10: The enable mask at 0x10 is read/write, and only the implemented status positions are kept (all ones reads back 0x0007F07D). `irq` is a register that holds the OR over status AND enable from the previous cycle. It therefore rises one cycle after an enabled bit sets and falls one cycle after the last enabled bit clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freeze | input | 1 | Clock-freeze flag; only wakeup latches while high |
| ev_susp | input | 1 | Suspend detected pulse |
| ev_sof | input | 1 | Start-of-frame detected pulse |
| sof_frame | input | 11 | Frame number accompanying `ev_sof` |
| ev_eorst | input | 1 | End-of-reset pulse |
| ev_wakeup | input | 1 | Filtered non-idle line pulse |
| ev_eorsm | input | 1 | End-of-resume pulse |
| ev_uprsm | input | 1 | Upstream resume sent pulse |
| ep_req | input | 7 | Endpoint interrupt request levels |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Registered interrupt request |

## Verification
Three pairs of functions can meet on the same clock edge, and the bench drives each pair onto one edge. An event pulse can coincide with a clear write for its own bit. A wakeup pulse can coincide with the suspend bit rising. An event pulse can coincide with the freeze flag. For each collision the bench predicts the winner from the requirements: the set holds against the clear, the suspend rise clears wakeup, and only wakeup passes the freeze. It then compares the whole status word, not just the bit in question. The same sweep over every bit checks the one-cycle lag of `irq` on both the rising and the falling side.

// File: rtl/usb_dev_irq_status.sv
module usb_dev_irq_status #(
  parameter int NEP     = 7,
  parameter int AW      = 8,
  parameter int DW      = 32,
  parameter int FNW     = 11,
  parameter int EP_LSB  = 12,
  parameter logic [AW-1:0] STAT_OFF = 8'h04,
  parameter logic [AW-1:0] CLR_OFF  = 8'h08,
  parameter logic [AW-1:0] EN_OFF   = 8'h10,
  parameter logic [AW-1:0] FN_OFF   = 8'h20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           freeze,
  input  logic           ev_susp,
  input  logic           ev_sof,
  input  logic [FNW-1:0] sof_frame,
  input  logic           ev_eorst,
  input  logic           ev_wakeup,
  input  logic           ev_eorsm,
  input  logic           ev_uprsm,
  input  logic [NEP-1:0] ep_req,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic           irq
);
  localparam int NLAT = 7;
  localparam int WAKE = 4;
  localparam logic [NLAT-1:0] LAT_MASK  = 7'b1111101;
  localparam logic [NLAT-1:0] FRZ_MASK  = 7'b0010000;

  logic [NLAT-1:0] lat_q, lat_d, ev_set, clr;
  logic [DW-1:0]   status, en_q, vmask;
  logic [FNW-1:0]  frame_q;
  logic            susp_rise;

  always_comb begin
    vmask = '0;
    vmask[NLAT-1:0] = LAT_MASK;
    vmask[EP_LSB +: NEP] = '1;
  end

  assign ev_set = {ev_uprsm, ev_eorsm, ev_wakeup, ev_eorst, ev_sof, 1'b0, ev_susp}
                & (freeze ? FRZ_MASK : LAT_MASK);
  assign clr = (wr_en && addr == CLR_OFF && !freeze) ? wdata[NLAT-1:0] : '0;
  assign susp_rise = ev_set[0] & ~lat_q[0];

  always_comb begin
    lat_d = ev_set | (lat_q & ~clr);
    if (susp_rise) lat_d[WAKE] = 1'b0;
  end

  always_comb begin
    status = '0;
    status[NLAT-1:0] = lat_q;
    status[EP_LSB +: NEP] = ep_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q   <= '0;
      en_q    <= '0;
      frame_q <= '0;
      irq     <= 1'b0;
    end else begin
      lat_q <= lat_d;
      irq   <= |(status & en_q);
      if (wr_en && addr == EN_OFF) en_q <= wdata & vmask;
      if (ev_sof && !freeze) frame_q <= sof_frame;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      STAT_OFF: rdata = status;
      EN_OFF:   rdata = en_q;
      FN_OFF:   rdata[FNW-1:0] = frame_q;
      default:  rdata = '0;
    endcase
  end
endmodule

module usb_dev_irq_status_chk #(
  parameter int AW  = 8,
  parameter int DW  = 32,
  parameter int FNW = 11,
  parameter logic [AW-1:0] CLR_OFF = 8'h08
) (
  input logic           clk,
  input logic           rst_n,
  input logic           freeze,
  input logic           ev_susp,
  input logic           ev_sof,
  input logic           ev_wakeup,
  input logic [FNW-1:0] sof_frame,
  input logic           wr_en,
  input logic [AW-1:0]  addr,
  input logic [DW-1:0]  wdata,
  input logic [6:0]     lat_q,
  input logic [DW-1:0]  status,
  input logic [DW-1:0]  en_q,
  input logic [FNW-1:0] frame_q,
  input logic           irq
);
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CLR_OFF && !freeze && wdata[2] && !ev_sof) |=> !lat_q[2]);
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sof && !freeze) |=> lat_q[2]);
  p_wake_susp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_susp && !lat_q[0] && !freeze) |=> (lat_q[0] && !lat_q[4]));
  p_freeze_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !ev_wakeup) |=> $stable(lat_q));
  p_wake_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_wakeup && !lat_q[4]) |=> !lat_q[4]);
  p_frame_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sof && !freeze) |=> frame_q == $past(sof_frame));
  p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status & en_q)) |=> irq);
  p_irq_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status & en_q)) |=> !irq);
endmodule

bind usb_dev_irq_status usb_dev_irq_status_chk #(
  .AW(AW), .DW(DW), .FNW(FNW), .CLR_OFF(CLR_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .freeze(freeze), .ev_susp(ev_susp), .ev_sof(ev_sof),
  .ev_wakeup(ev_wakeup), .sof_frame(sof_frame), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .lat_q(lat_q), .status(status), .en_q(en_q), .frame_q(frame_q),
  .irq(irq)
);

// File: tb/tb_usb_dev_irq_status.sv
module tb_usb_dev_irq_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        freeze = 1'b0;
  logic        ev_susp = 1'b0, ev_sof = 1'b0, ev_eorst = 1'b0;
  logic        ev_wakeup = 1'b0, ev_eorsm = 1'b0, ev_uprsm = 1'b0;
  logic [10:0] sof_frame = '0;
  logic [6:0]  ep_req = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h04;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, errors = 0;

  localparam logic [7:0] A_ST = 8'h04, A_CL = 8'h08, A_EN = 8'h10, A_FN = 8'h20;
  localparam int LBITS [6] = '{0, 2, 3, 4, 5, 6};

  always #4 clk = ~clk;

  usb_dev_irq_status dut (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .ev_susp(ev_susp), .ev_sof(ev_sof),
    .sof_frame(sof_frame), .ev_eorst(ev_eorst), .ev_wakeup(ev_wakeup),
    .ev_eorsm(ev_eorsm), .ev_uprsm(ev_uprsm), .ep_req(ep_req), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic set_ev(input int b, input logic v);
    case (b)
      0: ev_susp = v;
      2: ev_sof = v;
      3: ev_eorst = v;
      4: ev_wakeup = v;
      5: ev_eorsm = v;
      6: ev_uprsm = v;
      default: ;
    endcase
  endtask

  task automatic fire(input int b);
    set_ev(b, 1'b1);
    step();
    set_ev(b, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1
    rd_chk("R1 status", A_ST, 32'h0);
    rd_chk("R1 enable", A_EN, 32'h0);
    rd_chk("R1 frame", A_FN, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2, R3: each latched bit
    foreach (LBITS[k]) begin
      fire(LBITS[k]);
      rd_chk("R2 set", A_ST, 32'h1 << LBITS[k]);
      rd_chk("R3 clr reads zero", A_CL, 32'h0);
      wr(A_CL, ~(32'h1 << LBITS[k]) & 32'h7D);
      rd_chk("R3 zeros keep", A_ST, 32'h1 << LBITS[k]);
      wr(A_CL, 32'h1 << LBITS[k]);
      rd_chk("R3 clear", A_ST, 32'h0);
    end

    // R4: endpoint mirror
    for (int i = 0; i < 7; i++) begin
      ep_req = 7'(1 << i);
      rd_chk("R4 mirror", A_ST, 32'h1 << (12 + i));
      wr(A_CL, 32'hFFFF_FFFF);
      rd_chk("R4 clear immune", A_ST, 32'h1 << (12 + i));
      ep_req = '0;
      rd_chk("R4 follows", A_ST, 32'h0);
    end

    // R5: set vs clear same edge
    foreach (LBITS[k]) begin
      set_ev(LBITS[k], 1'b1);
      wr(A_CL, 32'h1 << LBITS[k]);
      set_ev(LBITS[k], 1'b0);
      rd_chk("R5 set wins", A_ST, 32'h1 << LBITS[k]);
      wr(A_CL, 32'h7D);
    end

    // R6: wakeup vs suspend
    fire(4);
    rd_chk("R6 wake set", A_ST, 32'h10);
    fire(0);
    rd_chk("R6 susp clears wake", A_ST, 32'h01);
    wr(A_CL, 32'h7D);
    ev_wakeup = 1'b1; ev_susp = 1'b1;
    step();
    ev_wakeup = 1'b0; ev_susp = 1'b0;
    rd_chk("R6 same edge", A_ST, 32'h01);
    fire(4);
    fire(0);
    rd_chk("R6 susp held keeps wake", A_ST, 32'h11);
    wr(A_CL, 32'h7D);

    // R7: freeze
    sof_frame = 11'h155;
    fire(2);
    wr(A_CL, 32'h7D);
    freeze = 1'b1;
    sof_frame = 11'h2AA;
    foreach (LBITS[k]) if (LBITS[k] != 4) fire(LBITS[k]);
    rd_chk("R7 events ignored", A_ST, 32'h0);
    rd_chk("R7 frame held", A_FN, 32'h155);
    fire(4);
    rd_chk("R7 wake latches", A_ST, 32'h10);
    wr(A_CL, 32'h10);
    rd_chk("R7 clear ignored", A_ST, 32'h10);
    freeze = 1'b0;
    wr(A_CL, 32'h10);
    rd_chk("R7 after thaw", A_ST, 32'h0);

    // R8
    fire(6);
    rd_chk("R8 uprsm only", A_ST, 32'h40);
    wr(A_CL, 32'h40);

    // R9: frame capture sweep
    for (int f = 0; f < 2048; f += 137) begin
      sof_frame = 11'(f);
      fire(2);
      rd_chk("R9 frame", A_FN, 32'(f));
    end
    sof_frame = 11'h7FF;
    fire(2);
    rd_chk("R9 frame max", A_FN, 32'h7FF);
    sof_frame = 11'h000;
    step();
    rd_chk("R9 no pulse", A_FN, 32'h7FF);
    wr(A_CL, 32'h7D);

    // R10: enable mask and irq timing
    wr(A_EN, 32'hFFFF_FFFF);
    rd_chk("R10 enable mask", A_EN, 32'h0007_F07D);
    foreach (LBITS[k]) begin
      wr(A_EN, 32'h1 << LBITS[k]);
      fire(LBITS[k]);
      check("R10 irq lag", {31'b0, irq}, 32'h0);
      step();
      check("R10 irq rise", {31'b0, irq}, 32'h1);
      wr(A_CL, 32'h7D);
      check("R10 irq held", {31'b0, irq}, 32'h1);
      step();
      check("R10 irq fall", {31'b0, irq}, 32'h0);
      wr(A_EN, ~(32'h1 << LBITS[k]));
      fire(LBITS[k]);
      step();
      check("R10 masked", {31'b0, irq}, 32'h0);
      wr(A_CL, 32'h7D);
    end
    for (int i = 0; i < 7; i++) begin
      wr(A_EN, 32'h1 << (12 + i));
      ep_req = 7'(1 << i);
      step();
      check("R10 ep irq", {31'b0, irq}, 32'h1);
      ep_req = '0;
      step();
      check("R10 ep irq fall", {31'b0, irq}, 32'h0);
      ep_req = 7'h7F & ~7'(1 << i);
      wr(A_EN, 32'h1 << (12 + i));
      step();
      check("R10 ep masked", {31'b0, irq}, 32'h0);
      ep_req = '0;
    end
    rd(A_ST, v);
    check("R10 final status", v, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule